// File: doc/BRIEF.md
# SSD-aligned 5B/4B receive decoder

This block sits after the descrambler in a 100 Mb/s receive path. It takes one code bit per accepted clock. While no frame is open, it slides a 10-bit window over the incoming bits one bit at a time and looks for the start-of-stream delimiter pair J then K. When it finds the pair, it fixes the 5-bit group boundary at that point. The boundary then stays fixed until the frame closes, so the next frame is aligned afresh.

Inside a frame, every 5 received bits form one code group. Each group is translated to a 4-bit nibble on a nibble-wide receive interface: `rxd`, a one-cycle `nib_stb`, `rx_dv`, `crs` and `rx_er`. The delimiter pair is handed on as two preamble nibbles. A T-then-R pair closes the frame. A run of `IDLE_END` idle groups also closes it. While no frame is open, carrier sense can also be raised by a stray pattern of line zeros. `rx_dv`, however, waits for a complete J/K match.

Top module: `ssd_rx_decoder`

## Requirements
- R1: After reset, `rx_dv`, `crs`, `rx_er` and `nib_stb` are all 0.
- R2: While no frame is open, the block checks the last 10 accepted bits at every bit for J=11000 followed by K=10001 (first bit leftmost). The match may fall at any bit offset. On a match, `rx_dv` rises with a strobe of `rxd`=0101 and `rx_er`=0. A second 0101 strobe follows in the next cycle.
- R3: After the delimiter, each further 5 accepted bits form one group. The group boundary is not re-derived during the frame. Data groups map to nibbles as follows (nibble:code): 0:11110 1:01001 2:10100 3:10101 4:01010 5:01011 6:01110 7:01111 8:10010 9:10011 A:10110 B:10111 C:11010 D:11011 E:11100 F:11101.
- R4: A T group (01101) directly followed by an R group (00111) closes the frame. `rx_dv` and `crs` fall, and neither group produces a strobe.
- R5: `IDLE_END` consecutive I groups (11111) close the frame. None of them produces a strobe.
- R6: A group inside a frame that is neither data nor a delimiter in its place gives one strobe with `rx_er`=1 and `rxd`=0000. The frame stays open.
- R7: A single I group, or a T group that is not followed by R, produces no strobe of its own. Instead, the next nibble strobed in that frame carries `rx_er`=1 together with its normal data.
- R8: While no frame is open, and after at least `ARM_ONES` consecutive ones, two zeros in the 10-bit window that are at least two positions apart raise `crs` without raising `rx_dv` or strobing. A window of all ones drops `crs` in the next cycle.
- R9: `crs` is 1 for every cycle that `rx_dv` is 1. `nib_stb` and `rx_er` are only ever 1 while `rx_dv` is 1.
- R10: Cycles with `bit_en`=0 shift nothing in. Gaps between bits do not change the decoded nibbles.
- R11: After a frame closes, the search resumes at once. A following frame at a different bit offset is decoded correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Code bit is present this cycle |
| code_bit | input | 1 | Descrambled code bit |
| rxd | output | 4 | Decoded nibble, valid with `nib_stb` |
| nib_stb | output | 1 | One-cycle nibble strobe |
| rx_dv | output | 1 | Frame open |
| crs | output | 1 | Carrier sense |
| rx_er | output | 1 | Nibble is in error, valid with `nib_stb` |

## Verification
The bench builds the block with `IDLE_END`=2 and `ARM_ONES`=10, which are the defaults. With these values, the double-idle close is reached with a single extra group. The false-carrier arming is reached with one 10-bit window of ones, so a short run of trailing idles is enough to check the quiet state after every frame. The random idle lengths and the random bit gaps move the delimiter across all five bit offsets. Directed frames cover invalid groups, broken T/R and idle sequences, back-to-back frames and a false carrier.

// File: rtl/ssd_rx_pkg.sv
package ssd_rx_pkg;
  localparam int GRP_W = 5;
  localparam int NIB_W = 4;
  localparam int WIN_W = 2 * GRP_W;

  localparam logic [GRP_W-1:0] SYM_J = 5'b11000;
  localparam logic [GRP_W-1:0] SYM_K = 5'b10001;
  localparam logic [GRP_W-1:0] SYM_T = 5'b01101;
  localparam logic [GRP_W-1:0] SYM_R = 5'b00111;
  localparam logic [GRP_W-1:0] SYM_I = 5'b11111;
  localparam logic [NIB_W-1:0] PRE_NIB = 4'b0101;

  typedef struct packed {
    logic             ok;
    logic [NIB_W-1:0] nib;
  } dec_t;

  typedef enum logic {ST_HUNT, ST_FRAME} rx_state_e;

  // Map a code group (first bit in the MSB) to its data nibble.
  function automatic dec_t decode_group(input logic [GRP_W-1:0] g);
    dec_t d;
    d.ok = 1'b1;
    case (g)
      5'b11110: d.nib = 4'h0;
      5'b01001: d.nib = 4'h1;
      5'b10100: d.nib = 4'h2;
      5'b10101: d.nib = 4'h3;
      5'b01010: d.nib = 4'h4;
      5'b01011: d.nib = 4'h5;
      5'b01110: d.nib = 4'h6;
      5'b01111: d.nib = 4'h7;
      5'b10010: d.nib = 4'h8;
      5'b10011: d.nib = 4'h9;
      5'b10110: d.nib = 4'hA;
      5'b10111: d.nib = 4'hB;
      5'b11010: d.nib = 4'hC;
      5'b11011: d.nib = 4'hD;
      5'b11100: d.nib = 4'hE;
      5'b11101: d.nib = 4'hF;
      default: begin
        d.ok  = 1'b0;
        d.nib = '0;
      end
    endcase
    return d;
  endfunction

  // True when the window holds two zeros with at least one bit between them.
  function automatic logic split_zeros(input logic [WIN_W-1:0] w);
    logic r;
    r = 1'b0;
    for (int i = 0; i < WIN_W; i++) begin
      for (int j = i + 2; j < WIN_W; j++) begin
        if (!w[i] && !w[j]) r = 1'b1;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/ssd_bit_window.sv
module ssd_bit_window #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bit_en,
  input  logic         code_bit,
  output logic [W-1:0] win,
  output logic         new_bit
);
  // Oldest bit in the MSB; reset to all ones so reset looks like an idle line.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win     <= '1;
      new_bit <= 1'b0;
    end else begin
      new_bit <= bit_en;
      if (bit_en) win <= {win[W-2:0], code_bit};
    end
  end
endmodule

// File: rtl/ssd_carrier_det.sv
module ssd_carrier_det import ssd_rx_pkg::*; #(
  parameter int ARM_ONES = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIN_W-1:0] win,
  input  logic             new_bit,
  input  logic             in_frame,
  output logic             false_carrier
);
  localparam int ARM_W = $clog2(ARM_ONES + 1);

  logic [ARM_W-1:0] ones_run;
  logic             armed;
  logic             run_full;

  assign run_full = (ones_run == ARM_W'(ARM_ONES));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ones_run      <= '0;
      armed         <= 1'b1;
      false_carrier <= 1'b0;
    end else begin
      if (new_bit) begin
        if (!win[0])       ones_run <= '0;
        else if (!run_full) ones_run <= ones_run + 1'b1;
      end
      if (in_frame)      armed <= 1'b0;
      else if (run_full) armed <= 1'b1;
      false_carrier <= armed && !in_frame && split_zeros(win);
    end
  end
endmodule

// File: rtl/ssd_frame_ctl.sv
module ssd_frame_ctl import ssd_rx_pkg::*; #(
  parameter int IDLE_END = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIN_W-1:0] win,
  input  logic             new_bit,
  output logic [NIB_W-1:0] rxd,
  output logic             nib_stb,
  output logic             rx_er,
  output logic             in_frame,
  output logic             ssd_hit,
  output logic             grp_done,
  output logic             end_hit
);
  localparam int CNT_W = $clog2(GRP_W);
  localparam int RUN_W = $clog2(IDLE_END + 1);

  rx_state_e        st;
  logic [CNT_W-1:0] cnt;
  logic             pre_pend;
  logic             t_pend;
  logic [RUN_W-1:0] idle_run;
  logic             err_carry;

  logic [GRP_W-1:0] grp;
  dec_t             dec;
  logic             is_t, is_r, is_i, broken;

  assign grp      = win[GRP_W-1:0];
  assign dec      = decode_group(grp);
  assign is_t     = (grp == SYM_T);
  assign is_r     = (grp == SYM_R);
  assign is_i     = (grp == SYM_I);
  assign broken   = t_pend || ((idle_run != '0) && !is_i);
  assign in_frame = (st == ST_FRAME);
  assign ssd_hit  = (st == ST_HUNT) && new_bit && (win == {SYM_J, SYM_K});
  assign grp_done = (st == ST_FRAME) && new_bit && (cnt == CNT_W'(GRP_W - 1));
  assign end_hit  = grp_done &&
                    ((t_pend && is_r) || (is_i && idle_run == RUN_W'(IDLE_END - 1)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_HUNT;
      cnt       <= '0;
      pre_pend  <= 1'b0;
      t_pend    <= 1'b0;
      idle_run  <= '0;
      err_carry <= 1'b0;
      rxd       <= '0;
      nib_stb   <= 1'b0;
      rx_er     <= 1'b0;
    end else begin
      nib_stb <= 1'b0;
      rx_er   <= 1'b0;
      if (st == ST_FRAME && new_bit)
        cnt <= (cnt == CNT_W'(GRP_W - 1)) ? '0 : cnt + 1'b1;
      if (ssd_hit) begin
        st        <= ST_FRAME;
        cnt       <= '0;
        pre_pend  <= 1'b1;
        t_pend    <= 1'b0;
        idle_run  <= '0;
        err_carry <= 1'b0;
        nib_stb   <= 1'b1;
        rxd       <= PRE_NIB;
      end else if (st == ST_FRAME) begin
        if (pre_pend) begin
          pre_pend <= 1'b0;
          nib_stb  <= 1'b1;
          rxd      <= PRE_NIB;
        end
        if (end_hit) begin
          st        <= ST_HUNT;
          t_pend    <= 1'b0;
          idle_run  <= '0;
          err_carry <= 1'b0;
        end else if (grp_done) begin
          if (is_t) begin
            t_pend    <= 1'b1;
            idle_run  <= '0;
            err_carry <= err_carry | broken;
          end else if (is_i) begin
            idle_run  <= idle_run + 1'b1;
            t_pend    <= 1'b0;
            err_carry <= err_carry | t_pend;
          end else begin
            nib_stb   <= 1'b1;
            rxd       <= dec.ok ? dec.nib : '0;
            rx_er     <= !dec.ok | err_carry | broken;
            err_carry <= 1'b0;
            t_pend    <= 1'b0;
            idle_run  <= '0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/ssd_rx_decoder.sv
module ssd_rx_decoder import ssd_rx_pkg::*; #(
  parameter int IDLE_END = 2,
  parameter int ARM_ONES = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             code_bit,
  output logic [NIB_W-1:0] rxd,
  output logic             nib_stb,
  output logic             rx_dv,
  output logic             crs,
  output logic             rx_er
);
  logic [WIN_W-1:0] win;
  logic             new_bit;
  logic             in_frame;
  logic             false_carrier;
  logic             ssd_hit;
  logic             grp_done;
  logic             end_hit;
  logic             line_quiet;

  assign line_quiet = &win;

  ssd_bit_window #(.W(WIN_W)) win_i (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .code_bit(code_bit),
    .win(win), .new_bit(new_bit)
  );

  ssd_carrier_det #(.ARM_ONES(ARM_ONES)) cd_i (
    .clk(clk), .rst_n(rst_n), .win(win), .new_bit(new_bit),
    .in_frame(in_frame), .false_carrier(false_carrier)
  );

  ssd_frame_ctl #(.IDLE_END(IDLE_END)) fc_i (
    .clk(clk), .rst_n(rst_n), .win(win), .new_bit(new_bit),
    .rxd(rxd), .nib_stb(nib_stb), .rx_er(rx_er), .in_frame(in_frame),
    .ssd_hit(ssd_hit), .grp_done(grp_done), .end_hit(end_hit)
  );

  assign rx_dv = in_frame;
  assign crs   = in_frame | false_carrier;
endmodule

// File: rtl/ssd_rx_decoder_chk.sv
module ssd_rx_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] rxd,
  input logic       nib_stb,
  input logic       rx_dv,
  input logic       crs,
  input logic       rx_er,
  input logic       ssd_hit,
  input logic       grp_done,
  input logic       end_hit,
  input logic       line_quiet
);
  p_pre_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_dv) |-> (nib_stb && rxd == 4'b0101 && !rx_er));
  p_pre_second_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_dv) |=> (nib_stb && rxd == 4'b0101));
  p_hit_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ssd_hit |=> rx_dv);
  p_group_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    grp_done |=> !grp_done);
  p_end_closes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    end_hit |=> (!rx_dv && !nib_stb));
  p_err_with_stb_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_er |-> nib_stb);
  p_quiet_drops_crs_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (line_quiet && !rx_dv) |=> !crs);
  p_dv_has_crs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_dv |-> crs);
  p_stb_in_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
    nib_stb |-> rx_dv);
endmodule

bind ssd_rx_decoder ssd_rx_decoder_chk chk_i (
  .clk(clk), .rst_n(rst_n), .rxd(rxd), .nib_stb(nib_stb), .rx_dv(rx_dv),
  .crs(crs), .rx_er(rx_er), .ssd_hit(ssd_hit), .grp_done(grp_done),
  .end_hit(end_hit), .line_quiet(line_quiet)
);

// File: tb/ssd_rx_decoder_tb_top.sv
`timescale 1ns/1ps
module ssd_rx_decoder_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_en = 1'b0;
  logic       code_bit = 1'b0;
  logic [3:0] rxd;
  logic       nib_stb, rx_dv, crs, rx_er;

  int  checks = 0;
  int  fails = 0;
  bit  done = 1'b0;
  bit  gaps = 1'b0;
  logic [4:0] got[$];
  logic [4:0] expq[$];

  always #2.5 clk = ~clk;

  ssd_rx_decoder #(.IDLE_END(2), .ARM_ONES(10)) dut_i (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .code_bit(code_bit),
    .rxd(rxd), .nib_stb(nib_stb), .rx_dv(rx_dv), .crs(crs), .rx_er(rx_er)
  );

  always @(negedge clk) if (rst_n && nib_stb) got.push_back({rx_er, rxd});

  function automatic logic [4:0] enc(input logic [3:0] n);
    logic [4:0] t [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101,
                           5'b01010, 5'b01011, 5'b01110, 5'b01111,
                           5'b10010, 5'b10011, 5'b10110, 5'b10111,
                           5'b11010, 5'b11011, 5'b11100, 5'b11101};
    return t[n];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic send_bit(input logic b);
    bit_en = 1'b1;
    code_bit = b;
    @(negedge clk);
    bit_en = 1'b0;
    if (gaps && ($urandom % 4 == 0)) @(negedge clk);
  endtask

  task automatic send_grp(input logic [4:0] g);
    for (int i = 4; i >= 0; i--) send_bit(g[i]);
  endtask

  task automatic send_ones(input int n);
    for (int i = 0; i < n; i++) send_bit(1'b1);
  endtask

  task automatic open_frame();
    send_grp(5'b11000);
    send_grp(5'b10001);
    expq.push_back(5'h05);
    expq.push_back(5'h05);
  endtask

  task automatic data_nib(input logic [3:0] n, input bit err);
    send_grp(enc(n));
    expq.push_back({err, n});
  endtask

  // Compare collected nibbles and the closed state after trailing idles.
  task automatic finish_frame(input string req);
    send_ones(16);
    repeat (3) @(negedge clk);
    chk(got.size() == expq.size(), {req, " nibble count"}, got.size(), expq.size());
    for (int i = 0; i < expq.size() && i < got.size(); i++)
      chk(got[i] === expq[i], {req, " R3 nibble"}, got[i], expq[i]);
    chk(rx_dv == 1'b0, {req, " rx_dv closed"}, rx_dv, 0);
    chk(crs == 1'b0, {req, " crs closed"}, crs, 0);
    got.delete();
    expq.delete();
  endtask

  initial begin
    void'($urandom(32'd5417));
    repeat (4) @(negedge clk);
    chk(rx_dv == 0 && crs == 0 && rx_er == 0 && nib_stb == 0, "R1 reset outputs",
        {rx_dv, crs, rx_er, nib_stb}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rx_dv == 0 && crs == 0 && nib_stb == 0, "R1 after release",
        {rx_dv, crs, nib_stb}, 0);

    // R4 directed T/R close, no gaps
    send_ones(12);
    open_frame();
    data_nib(4'h3, 0); data_nib(4'hE, 0);
    send_grp(5'b01101); send_grp(5'b00111);
    finish_frame("R4");

    // R6 invalid group mid-frame
    send_ones(13);
    open_frame();
    data_nib(4'hA, 0);
    send_grp(5'b00000); expq.push_back(5'h10);
    data_nib(4'hB, 0);
    send_grp(5'b01101); send_grp(5'b00111);
    finish_frame("R6");

    // R7 lone idle, R5 double idle close
    send_ones(11);
    open_frame();
    data_nib(4'hA, 0);
    send_grp(5'b11111);
    data_nib(4'hB, 1);
    send_grp(5'b11111); send_grp(5'b11111);
    finish_frame("R7 R5");

    // R7 T not followed by R
    send_ones(14);
    open_frame();
    data_nib(4'hA, 0);
    send_grp(5'b01101);
    data_nib(4'hC, 1);
    data_nib(4'h0, 0);
    send_grp(5'b01101); send_grp(5'b00111);
    finish_frame("R7");

    // R11 back-to-back frames with a short idle between
    send_ones(12);
    open_frame();
    data_nib(4'h7, 0);
    send_grp(5'b01101); send_grp(5'b00111);
    send_ones(3);
    open_frame();
    data_nib(4'h9, 0);
    send_grp(5'b01101); send_grp(5'b00111);
    finish_frame("R11");

    // R8 false carrier: split zeros raise crs only
    send_ones(20);
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    repeat (2) @(negedge clk);
    chk(crs == 1'b1, "R8 false carrier crs", crs, 1);
    chk(rx_dv == 1'b0, "R8 false carrier rx_dv", rx_dv, 0);
    send_ones(12);
    repeat (2) @(negedge clk);
    chk(crs == 1'b0, "R8 crs drops on quiet line", crs, 0);
    chk(got.size() == 0, "R8 no strobes", got.size(), 0);
    got.delete();

    // R10 R2 random frames with random offsets and bit gaps
    gaps = 1'b1;
    for (int f = 0; f < 24; f++) begin
      send_ones(12 + ($urandom % 20));
      open_frame();
      for (int k = 0; k < 4 + ($urandom % 28); k++) data_nib(4'($urandom % 16), 0);
      if ($urandom % 2) begin
        send_grp(5'b01101); send_grp(5'b00111);
      end else begin
        send_grp(5'b11111); send_grp(5'b11111);
      end
      finish_frame("R10 R2 random");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule